// File: doc/BRIEF.md
# Two-Level Descriptor Cookie Translator

The translator turns a 20-bit descriptor cookie into the 64-bit word that the cookie stands for. The upper eleven cookie bits pick an entry in a primary page table kept in on-chip memory; that entry gives the physical base of a secondary page in external memory. The lower nine bits pick one of 512 eight-byte slots in that page. The block reads the primary entry, forms the slot address, fetches the slot over an external read port and returns its contents.

The block handles one lookup at a time, using a valid/ready request handshake and a one-cycle done pulse on the result. A mode input, sampled with each request, selects how primary entries are packed. In packed mode each entry is 4 bytes and holds a 4 KiB page number. In wide mode each entry is 8 bytes and holds the full page address. Primary indices beyond the table size set by the parameters are rejected without any memory traffic.

Top module: `cookie_xlate`

## Requirements
- R1: After reset, reqReady is 1 and rspDone, ptRdEn and extReqValid are 0.
- R2: With alignedMode=1 (packed mode), the primary memory word address is cookie[19:10], and cookie bit 9 selects the entry half: 1 selects bits [63:32] and 0 selects bits [31:0].
- R3: In packed mode the page base is the 32-bit entry shifted left by 12 bits, with zero fill.
- R4: With alignedMode=0 (wide mode), the primary word address is cookie[19:9], and the page base is the low ADDR_W bits of the 64-bit word.
- R5: The external read address is the page base plus cookie[8:0] times 8.
- R6: The word returned on the external response appears on rspData with rspError=0, and rspDone is a single-cycle pulse.
- R7: A primary index cookie[19:9] that is not below PT_BYTES/4 (packed) or PT_BYTES/8 (wide) ends with rspDone and rspError=1. No primary read and no external request are issued for it.
- R8: reqReady stays 0 from an accepted request until its done pulse. An external request holds extReqValid and extReqAddr steady until extReqReady is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| alignedMode | input | 1 | 1 = 4-byte packed entries, 0 = 8-byte entries; sampled with a request |
| reqValid | input | 1 | Lookup request valid |
| reqReady | output | 1 | Block can accept a lookup |
| reqCookie | input | 20 | Descriptor cookie |
| rspDone | output | 1 | One-cycle result strobe |
| rspData | output | 64 | Translated word |
| rspError | output | 1 | Index out of table range |
| ptRdEn | output | 1 | Primary table read enable |
| ptAddr | output | PT_AW | Primary table 64-bit word address |
| ptRdData | input | 64 | Primary word, valid one cycle after ptRdEn |
| extReqValid | output | 1 | External read request valid |
| extReqReady | input | 1 | External read request accepted |
| extReqAddr | output | ADDR_W | External byte address |
| extRspValid | input | 1 | External read data valid |
| extRspData | input | 64 | External read data |

## Verification
The bench sweeps every primary index in both modes on a 4 KiB table, so the range edge at 1024 packed entries and 512 wide entries is hit from both sides. A design that gets the limit wrong by one would fetch from a nonexistent entry or reject the last valid one. Odd and even indices in packed mode check the half select; a swapped half gives a base that is off by one page. Slot offsets 0 and 511 and varied ready delays on the external port check the times-8 scaling and that the request stays steady. A missing shift, or a request that changes while it waits, shows up as a wrong captured address.

// File: rtl/cookie_xlate_pkg.sv
package cookie_xlate_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;   // latch cookie and mode
    logic capBase;  // latch page base from primary word
    logic capData;  // latch external word
  } xlateStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_PTWAIT,
    ST_EXTREQ,
    ST_EXTWAIT,
    ST_FINISH
  } xlateState_t;

endpackage

// File: rtl/cookie_xlate_dp.sv
module cookie_xlate_dp
  import cookie_xlate_pkg::*;
#(
  parameter int SLOT_W   = 9,
  parameter int IDX_W    = 11,
  parameter int PT_BYTES = 8192,
  parameter int ADDR_W   = 48,
  parameter int PT_AW    = 10,
  localparam int COOKIE_W = SLOT_W + IDX_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  xlateStrobe_t        strobe,
  input  logic                alignedMode,
  input  logic [COOKIE_W-1:0] reqCookie,
  input  logic [63:0]         ptRdData,
  input  logic [63:0]         extRspData,
  output logic                inRange,
  output logic [PT_AW-1:0]    ptAddr,
  output logic [ADDR_W-1:0]   extReqAddr,
  output logic [63:0]         rspData
);
  localparam int PACKED_ENTRIES = PT_BYTES / 4;
  localparam int WIDE_ENTRIES   = PT_BYTES / 8;
  localparam int PAGE_SHIFT     = 12;
  localparam int HALF_W         = 32;

  logic [COOKIE_W-1:0] cookieQ;
  logic                modeQ;
  logic [ADDR_W-1:0]   baseQ;
  logic [63:0]         dataQ;

  logic [IDX_W-1:0]    idx;
  logic [SLOT_W-1:0]   slot;
  logic [IDX_W-1:0]    wordIdx;
  logic [HALF_W-1:0]   halfEntry;
  logic [ADDR_W-1:0]   packedBase;
  logic [ADDR_W-1:0]   wideBase;

  assign idx  = cookieQ[COOKIE_W-1:SLOT_W];
  assign slot = cookieQ[SLOT_W-1:0];

  // packed mode: two entries share a 64-bit word
  assign wordIdx = modeQ ? {1'b0, idx[IDX_W-1:1]} : idx;
  assign ptAddr  = wordIdx[PT_AW-1:0];

  assign inRange = modeQ ? (32'(idx) < PACKED_ENTRIES) : (32'(idx) < WIDE_ENTRIES);

  assign halfEntry  = idx[0] ? ptRdData[63:32] : ptRdData[31:0];
  assign packedBase = ADDR_W'({halfEntry, {PAGE_SHIFT{1'b0}}});
  assign wideBase   = ptRdData[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cookieQ <= '0;
      modeQ   <= 1'b0;
      baseQ   <= '0;
      dataQ   <= '0;
    end else begin
      if (strobe.capReq) begin
        cookieQ <= reqCookie;
        modeQ   <= alignedMode;
      end
      if (strobe.capBase) baseQ <= modeQ ? packedBase : wideBase;
      if (strobe.capData) dataQ <= extRspData;
    end
  end

  assign extReqAddr = baseQ + (ADDR_W'(slot) << 3);
  assign rspData    = dataQ;

endmodule

// File: rtl/cookie_xlate_ctrl.sv
module cookie_xlate_ctrl
  import cookie_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         inRange,
  input  logic         extReqReady,
  input  logic         extRspValid,
  output logic         reqReady,
  output logic         ptRdEn,
  output logic         extReqValid,
  output logic         rspDone,
  output logic         rspError,
  output xlateStrobe_t strobe
);
  xlateState_t state, nextState;
  logic        errQ, errNext;

  always_comb begin
    nextState = state;
    errNext   = errQ;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.capReq = 1'b1;
        nextState     = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        errNext   = !inRange;
        nextState = inRange ? ST_PTWAIT : ST_FINISH;
      end
      ST_PTWAIT: begin
        strobe.capBase = 1'b1;
        nextState      = ST_EXTREQ;
      end
      ST_EXTREQ:  if (extReqReady) nextState = ST_EXTWAIT;
      ST_EXTWAIT: if (extRspValid) begin
        strobe.capData = 1'b1;
        nextState      = ST_FINISH;
      end
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= nextState;
      errQ  <= errNext;
    end
  end

  assign reqReady    = (state == ST_IDLE);
  assign ptRdEn      = (state == ST_LOOKUP) && inRange;
  assign extReqValid = (state == ST_EXTREQ);
  assign rspDone     = (state == ST_FINISH);
  assign rspError    = (state == ST_FINISH) && errQ;

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_error_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone && rspError) |-> $past(!ptRdEn) && !extReqValid);

endmodule

// File: rtl/cookie_xlate.sv
module cookie_xlate
  import cookie_xlate_pkg::*;
#(
  parameter int SLOT_W   = 9,
  parameter int IDX_W    = 11,
  parameter int PT_BYTES = 8192,
  parameter int ADDR_W   = 48,
  localparam int COOKIE_W = SLOT_W + IDX_W,
  localparam int PT_AW    = $clog2(PT_BYTES / 8)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                alignedMode,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [COOKIE_W-1:0] reqCookie,
  output logic                rspDone,
  output logic [63:0]         rspData,
  output logic                rspError,
  output logic                ptRdEn,
  output logic [PT_AW-1:0]    ptAddr,
  input  logic [63:0]         ptRdData,
  output logic                extReqValid,
  input  logic                extReqReady,
  output logic [ADDR_W-1:0]   extReqAddr,
  input  logic                extRspValid,
  input  logic [63:0]         extRspData
);
  xlateStrobe_t strobe;
  logic         inRange;

  cookie_xlate_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .inRange     (inRange),
    .extReqReady (extReqReady),
    .extRspValid (extRspValid),
    .reqReady    (reqReady),
    .ptRdEn      (ptRdEn),
    .extReqValid (extReqValid),
    .rspDone     (rspDone),
    .rspError    (rspError),
    .strobe      (strobe)
  );

  cookie_xlate_dp #(
    .SLOT_W   (SLOT_W),
    .IDX_W    (IDX_W),
    .PT_BYTES (PT_BYTES),
    .ADDR_W   (ADDR_W),
    .PT_AW    (PT_AW)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .alignedMode (alignedMode),
    .reqCookie   (reqCookie),
    .ptRdData    (ptRdData),
    .extRspData  (extRspData),
    .inRange     (inRange),
    .ptAddr      (ptAddr),
    .extReqAddr  (extReqAddr),
    .rspData     (rspData)
  );

  assert_ext_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (extReqValid && !extReqReady) |=> extReqValid && $stable(extReqAddr));

endmodule

// File: tb/cookie_xlate_test.sv
module cookie_xlate_test;
  localparam int PT_BYTES = 4096;
  localparam int ADDR_W   = 48;
  localparam int PT_AW    = $clog2(PT_BYTES / 8);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              alignedMode = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [19:0]       reqCookie = '0;
  logic              rspDone;
  logic [63:0]       rspData;
  logic              rspError;
  logic              ptRdEn;
  logic [PT_AW-1:0]  ptAddr;
  logic [63:0]       ptRdData = '0;
  logic              extReqValid;
  logic              extReqReady = 1'b0;
  logic [ADDR_W-1:0] extReqAddr;
  logic              extRspValid = 1'b0;
  logic [63:0]       extRspData = '0;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  cookie_xlate #(.PT_BYTES(PT_BYTES), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .alignedMode(alignedMode),
    .reqValid(reqValid), .reqReady(reqReady), .reqCookie(reqCookie),
    .rspDone(rspDone), .rspData(rspData), .rspError(rspError),
    .ptRdEn(ptRdEn), .ptAddr(ptAddr), .ptRdData(ptRdData),
    .extReqValid(extReqValid), .extReqReady(extReqReady), .extReqAddr(extReqAddr),
    .extRspValid(extRspValid), .extRspData(extRspData)
  );

  function automatic logic [63:0] ptWord(int w);
    logic [31:0] lo;
    lo = 32'h0003_0000 + 32'(2 * w);
    return {lo + 32'd1, lo};
  endfunction

  function automatic logic [63:0] extWord(logic [ADDR_W-1:0] a);
    return {a[31:0] ^ 32'hC3A5_5A3C, a[47:16]};
  endfunction

  // primary table model: one-cycle registered read
  always_ff @(posedge clk) if (ptRdEn) ptRdData <= ptWord(int'(ptAddr));

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic mode, input int idx, input int slot, input int delay);
    logic [19:0]       ck;
    logic              inR, sawPt, sawExt, finished;
    logic [PT_AW-1:0]  gotPt;
    logic [ADDR_W-1:0] gotAddr, expBase, expAddr;
    logic [63:0]       gotData;
    logic              gotErr;
    int                expPt;
    ck    = {idx[10:0], slot[8:0]};
    inR   = mode ? (idx < PT_BYTES / 4) : (idx < PT_BYTES / 8);
    expPt = mode ? idx / 2 : idx;
    if (mode) begin
      logic [63:0] w;
      w = ptWord(idx / 2);
      expBase = ADDR_W'({(idx % 2 == 1) ? w[63:32] : w[31:0], 12'h000}); // R2 R3
    end else begin
      expBase = ptWord(idx)[ADDR_W-1:0];  // R4
    end
    expAddr = expBase + ADDR_W'(slot * 8);  // R5
    sawPt = 0; sawExt = 0; finished = 0; gotPt = '0; gotAddr = '0; gotData = '0; gotErr = 0;

    @(negedge clk);
    alignedMode = mode; reqCookie = ck; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R8 busy after accept", {63'd0, reqReady}, 64'd0);
    for (int c = 0; c < 40 && !finished; c++) begin
      if (rspDone) begin
        finished = 1; gotData = rspData; gotErr = rspError;
      end else begin
        if (ptRdEn) begin sawPt = 1; gotPt = ptAddr; end
        if (extReqValid && !sawExt) begin
          sawExt = 1; gotAddr = extReqAddr;
          for (int d = 0; d < delay; d++) begin
            @(negedge clk);
            if (!extReqValid || extReqAddr != gotAddr) begin
              nChecks++; nFails++;
              $display("FAIL R8 request not held actual=%h expected=%h", extReqAddr, gotAddr);
            end
          end
          extReqReady = 1'b1;
          @(negedge clk);
          extReqReady = 1'b0;
          extRspValid = 1'b1; extRspData = extWord(gotAddr);
        end
        @(negedge clk);
        extRspValid = 1'b0;
      end
    end
    check(finished, "R6 done seen", {63'd0, finished}, 64'd1);
    if (inR) begin
      check(sawPt && int'(gotPt) == expPt, mode ? "R2 primary word address" : "R4 primary word address",
            64'(gotPt), 64'(expPt));
      check(gotAddr == expAddr, "R5 external address", 64'(gotAddr), 64'(expAddr));
      check(!gotErr && gotData == extWord(expAddr), "R6 returned word", gotData, extWord(expAddr));
    end else begin
      check(gotErr && !sawPt && !sawExt, "R7 out of range rejected",
            {61'd0, gotErr, sawPt, sawExt}, 64'd4);
    end
    @(negedge clk);
    check(!rspDone, "R6 done is one pulse", {63'd0, rspDone}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady && !rspDone && !ptRdEn && !extReqValid, "R1 reset state",
          {60'd0, reqReady, rspDone, ptRdEn, extReqValid}, 64'h8);
    rstN = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 2048; i++) begin
        lookup(m[0], i, (i * 37 + m * 5) % 512, i % 4);
      end
      // slot extremes around range edges
      lookup(m[0], 0, 0, 0);
      lookup(m[0], 0, 511, 1);
      lookup(m[0], 511, 511, 2);
      lookup(m[0], 512, 0, 0);
      lookup(m[0], 1023, 511, 3);
      lookup(m[0], 1024, 511, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule